// File: doc/BRIEF.md
# Dual-Accumulator Multiply-Accumulate Unit

This block is a single-cycle 16x16 multiply-accumulate datapath for fixed-point filter kernels. Each enabled cycle it multiplies two 16-bit operands and, depending on a 2-bit command, loads the product into one of two 40-bit accumulators, adds it, subtracts it, or clears the accumulator. Each operand carries its own signed/unsigned mode, so partial products of wider numbers can be chained for multi-precision arithmetic. The 34-bit product is sign-extended to 40 bits before it is used.

The accumulators are held in two banks, primary and secondary. A one-cycle bank toggle exchanges the active set, so a task switch does not need to save or restore accumulator contents. The outputs show the accumulator chosen by the select input in the active bank. They give the full 40-bit value, a 16-bit result taken from bits 31..16 with clamping, and an overflow flag. Nothing is pipelined: a write is visible on the outputs in the cycle after the clock edge that performs it.

Top module: `dual_mac`

## Requirements
- R1: After reset, every accumulator in both banks is zero and the primary bank is active. `acc_out`, `sat_out` and `ovf` all read zero.
- R2: Command 0 (load) with `en` high writes the 40-bit sign-extended product into the selected accumulator. The value appears on `acc_out` in the cycle after the clock edge. For example, signed 0xFFFD times signed 5 gives 0xFFFFFFFFF1.
- R3: Command 1 (add) with `en` high adds the product to the selected accumulator.
- R4: Command 2 (subtract) with `en` high subtracts the product from the selected accumulator.
- R5: Command 3 (clear) with `en` high zeroes only the selected accumulator of the active bank.
- R6: When an operand's signed flag is low, that operand is treated as unsigned. For example, 0xFFFF times 0xFFFF with both flags low gives 0x00FFFE0001. With `a` unsigned and `b` signed, 0xFFFF times 0xFFFF gives 0xFFFFFF0001.
- R7: The two accumulators (`acc_sel` 0 and 1) are independent. A command changes only the one selected.
- R8: A pulse on `bank_swap` toggles the active bank. The accumulators of the inactive bank keep their values.
- R9: When `bank_swap` and an enabled command occur in the same cycle, the command writes into the bank that was active before the toggle.
- R10: `ovf` is high exactly when bits 39..31 of the shown accumulator are not all equal.
- R11: Without overflow, `sat_out` equals bits 31..16 of the shown accumulator. With overflow it is 0x7FFF when bit 39 is 0 and 0x8000 when bit 39 is 1.
- R12: With `en` low, no accumulator changes, whatever the command and operands are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Execute the command this cycle |
| op | input | 2 | Command: 0 load, 1 add, 2 subtract, 3 clear |
| acc_sel | input | 1 | Accumulator targeted by the command and shown on outputs |
| a_signed | input | 1 | Operand `a` is signed when high |
| b_signed | input | 1 | Operand `b` is signed when high |
| a | input | 16 | First operand |
| b | input | 16 | Second operand |
| bank_swap | input | 1 | Toggle the active bank at this edge |
| acc_out | output | 40 | Selected accumulator of the active bank |
| sat_out | output | 16 | Bits 31..16 of `acc_out`, clamped on overflow |
| ovf | output | 1 | Guard bits and bit 31 disagree |

## Verification
The hardest situations to reach from the ports are overflow into the guard bits in the negative direction, and a bank toggle that coincides with a write. For overflow, the bench repeatedly accumulates the most negative by most positive product until bit 31 leaves the sign run while bit 39 stays set. For the coincident case, it issues a command in the same cycle as the toggle, then reads both banks by toggling back. That shows the write landed in the old bank and left the new one untouched.

// File: rtl/dual_mac.sv
module dual_mac #(
  parameter int OPW  = 16,
  parameter int ACCW = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [1:0]       op,
  input  logic             acc_sel,
  input  logic             a_signed,
  input  logic             b_signed,
  input  logic [OPW-1:0]   a,
  input  logic [OPW-1:0]   b,
  input  logic             bank_swap,
  output logic [ACCW-1:0]  acc_out,
  output logic [OPW-1:0]   sat_out,
  output logic             ovf
);
  localparam int PW = 2*OPW + 2;
  localparam int LO = 2*OPW - 1;
  localparam logic [1:0] OP_LOAD = 2'd0, OP_ADD = 2'd1, OP_SUB = 2'd2, OP_CLR = 2'd3;
  localparam logic [OPW-1:0] POS_MAX = {1'b0, {(OPW-1){1'b1}}};
  localparam logic [OPW-1:0] NEG_MAX = {1'b1, {(OPW-1){1'b0}}};

  logic [ACCW-1:0] acc_q [2][2];
  logic            bank_q;
  logic [ACCW-1:0] nxt;

  wire signed [OPW:0]  ax   = {a_signed & a[OPW-1], a};
  wire signed [OPW:0]  bx   = {b_signed & b[OPW-1], b};
  wire signed [PW-1:0] prod = ax * bx;
  wire [ACCW-1:0]      prod_x = {{(ACCW-PW){prod[PW-1]}}, prod};
  wire [ACCW-1:0]      cur  = acc_q[bank_q][acc_sel];

  always_comb begin
    case (op)
      OP_LOAD: nxt = prod_x;
      OP_ADD:  nxt = cur + prod_x;
      OP_SUB:  nxt = cur - prod_x;
      default: nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_q <= 1'b0;
      for (int k = 0; k < 2; k++)
        for (int j = 0; j < 2; j++)
          acc_q[k][j] <= '0;
    end else begin
      if (en) acc_q[bank_q][acc_sel] <= nxt;
      if (bank_swap) bank_q <= ~bank_q;
    end
  end

  wire [ACCW-LO-1:0] top = cur[ACCW-1:LO];
  assign acc_out = cur;
  assign ovf     = !((&top) || !(|top));
  assign sat_out = ovf ? (cur[ACCW-1] ? NEG_MAX : POS_MAX) : cur[LO:OPW];

  a_r8_swap_toggles: assert property (@(posedge clk) disable iff (!rst_n)
    bank_swap |=> bank_q != $past(bank_q));
  a_r12_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !bank_swap) |=> ($stable(acc_sel) -> $stable(acc_out)));
  a_r5_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op == OP_CLR && !bank_swap) |=> ($stable(acc_sel) -> acc_out == '0));
  a_r3_add_sum: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op == OP_ADD && !bank_swap) |=>
      ($stable(acc_sel) -> acc_out == $past(acc_out) + $past(prod_x)));
  a_r11_clamp: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> (sat_out == POS_MAX || sat_out == NEG_MAX));
endmodule

// File: tb/sim_dual_mac.sv
module sim_dual_mac;
  logic clk = 0, rst_n = 0, en = 0, acc_sel = 0, a_signed = 1, b_signed = 1, bank_swap = 0;
  logic [1:0] op = 0;
  logic [15:0] a = 0, b = 0;
  logic [39:0] acc_out;
  logic [15:0] sat_out;
  logic ovf;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  dual_mac u0 (.clk, .rst_n, .en, .op, .acc_sel, .a_signed, .b_signed, .a, .b,
               .bank_swap, .acc_out, .sat_out, .ovf);

  task automatic chk(string req, logic [39:0] act, logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(logic [1:0] o, logic sel, logic [15:0] x, logic [15:0] y,
                       logic sx = 1, logic sy = 1, logic e = 1, logic sw = 0);
    @(negedge clk);
    op = o; acc_sel = sel; a = x; b = y; a_signed = sx; b_signed = sy; en = e; bank_swap = sw;
    @(negedge clk);
    en = 0; bank_swap = 0;
  endtask

  task automatic view(logic sel);
    @(negedge clk); acc_sel = sel; #1;
  endtask

  task automatic toggle();
    @(negedge clk); bank_swap = 1;
    @(negedge clk); bank_swap = 0;
  endtask

  task automatic t_reset();
    view(0); chk("R1", acc_out, 0); chk("R1", {39'd0, ovf}, 0); chk("R1", sat_out, 0);
    view(1); chk("R1", acc_out, 0);
  endtask

  task automatic t_arith();
    issue(0, 0, 16'hFFFD, 16'd5); #1;
    chk("R2", acc_out, 40'hFFFFFFFFF1); chk("R11", sat_out, 16'hFFFF); chk("R10", ovf, 0);
    issue(1, 0, 16'd2, 16'd3); #1; chk("R3", acc_out, 40'hFFFFFFFFF7);
    issue(2, 0, 16'd4, 16'd4); #1; chk("R4", acc_out, 40'hFFFFFFFFE7);
  endtask

  task automatic t_unsigned();
    issue(0, 1, 16'hFFFF, 16'hFFFF, 0, 0); #1;
    chk("R6", acc_out, 40'h00FFFE0001); chk("R10", ovf, 1); chk("R11", sat_out, 16'h7FFF);
    issue(0, 1, 16'hFFFF, 16'hFFFF, 0, 1); #1; chk("R6", acc_out, 40'hFFFFFF0001);
    view(0); chk("R7", acc_out, 40'hFFFFFFFFE7);
  endtask

  task automatic t_idle_clear();
    issue(1, 0, 16'd100, 16'd100, 1, 1, 0); #1; chk("R12", acc_out, 40'hFFFFFFFFE7);
    issue(3, 1, 16'd0, 16'd0); #1; chk("R5", acc_out, 0);
    view(0); chk("R5", acc_out, 40'hFFFFFFFFE7);
  endtask

  task automatic t_overflow();
    issue(0, 1, 16'h7FFF, 16'h7FFF); issue(1, 1, 16'h7FFF, 16'h7FFF); #1;
    chk("R11", sat_out, 16'h7FFE); chk("R10", ovf, 0);
    issue(1, 1, 16'h7FFF, 16'h7FFF); #1;
    chk("R3", acc_out, 40'h00BFFD0003); chk("R10", ovf, 1); chk("R11", sat_out, 16'h7FFF);
    issue(0, 1, 16'h8000, 16'h7FFF); #1; chk("R2", acc_out, 40'hFFC0008000);
    issue(1, 1, 16'h8000, 16'h7FFF); #1; chk("R10", ovf, 0); chk("R11", sat_out, 16'h8001);
    issue(1, 1, 16'h8000, 16'h7FFF); #1;
    chk("R3", acc_out, 40'hFF40018000); chk("R10", ovf, 1); chk("R11", sat_out, 16'h8000);
  endtask

  task automatic t_banks();
    toggle(); view(0); chk("R8", acc_out, 0);
    issue(0, 0, 16'd7, 16'd1); #1; chk("R8", acc_out, 40'd7);
    toggle(); view(0); chk("R8", acc_out, 40'hFFFFFFFFE7);
    issue(0, 0, 16'd2, 16'd2, 1, 1, 1, 1); #1; chk("R9", acc_out, 40'd7);
    toggle(); view(0); chk("R9", acc_out, 40'd4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset(); t_arith(); t_unsigned(); t_idle_clear(); t_overflow(); t_banks();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule